// File: doc/BRIEF.md
# Multiplexed-Bus Parallel Port Controller

This peripheral sits on a shared address/data bus and gives a host two 8-bit general-purpose ports. Each port has an output latch and a direction register that marks every pin as an input or an output. During the address phase the host raises the address strobe `ale`. While it is high, the block captures the two low bus bits as a register select. It also captures whether the chip is selected and whether the cycle targets I/O space. The data phase then reuses the same bus lines.

A write takes place while the active-low I/O write strobe is low. A read places data on the bus. It can be started in two ways: by the active-low I/O read strobe, or by the memory read strobe when the address phase flagged I/O space. The bus is modelled as separate in, out and output-enable signals. Each port pin is modelled the same way. All state is sampled on the rising edge of `clk`. The reset input is synchronous and active high.

Top module: `mux_bus_pio`

## Requirements
- R1: While `ale` is high, `bus_in[1:0]`, the chip-select condition and `io_sel` are captured on every clock. Once `ale` is low, they are held, and data-phase values on `bus_in[1:0]` do not change the register target.
- R2: The register select encoding is 00 for the port A output latch, 01 for the port B output latch, 10 for the port A direction register and 11 for the port B direction register. A clock edge with `ale` low, a held chip select and `io_wr_n` low writes `bus_in` into the selected register.
- R3: A direction bit of 1 makes that pin an output. `pa_oe`/`pb_oe` equal the direction registers, and `pa_out`/`pb_out` equal the output latches. Writing 0xFF to a direction register makes all eight pins outputs, so later data writes appear on the pins.
- R4: The chip is selected only when `ce_hi` is 1 and `ce_lo_n` is 0 during the address phase. Otherwise, writes are ignored and the bus is never driven.
- R5: With the chip selected and `ale` low, `io_rd_n` low drives the bus (`bus_oe` = 1).
- R6: `mem_rd_n` low drives the bus only when `io_sel` was 1 in the address phase. If `io_sel` was 0, the bus stays undriven.
- R7: A read of a direction register returns its stored value. A read of a data register returns the pin input for input bits and the output latch for output bits.
- R8: `bus_oe` is 0 whenever `ale` is high or no qualified read strobe is active.
- R9: Reset clears both direction registers, both output latches and the held chip select. After reset, a port read returns the externally driven pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ale | input | 1 | Address phase strobe |
| ce_hi | input | 1 | Active-high chip enable |
| ce_lo_n | input | 1 | Active-low chip enable |
| io_sel | input | 1 | 1 = I/O space cycle, captured in address phase |
| mem_rd_n | input | 1 | Memory read strobe, active low |
| io_rd_n | input | 1 | I/O read strobe, active low |
| io_wr_n | input | 1 | I/O write strobe, active low |
| bus_in | input | 8 | Shared bus, host to block |
| bus_out | output | 8 | Shared bus, block to host |
| bus_oe | output | 1 | Shared bus output enable |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-pin output enable |

## Verification
Direction registers and output latches show up on the pin outputs in the cycle after the write edge. A corrupted register is therefore visible on `pa_oe`/`pb_oe`/`pa_out`/`pb_out` one clock later. A wrong held select or chip-select bit stays hidden until the next strobe: the read steers the wrong register onto `bus_out`, or the write lands in the wrong place, and it appears in that same data phase. The bench model tracks every register and compares each output on every clock, so it catches such faults at the first strobe that exposes them.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      SEL_A_DATA = 2'b00,
      SEL_B_DATA = 2'b01,
      SEL_A_DIR  = 2'b10,
      SEL_B_DIR  = 2'b11
   } pio_sel_e;

   localparam int unsigned NPORT = 2;
endpackage

// File: rtl/pio_addr_latch.sv
module pio_addr_latch
   import pio_pkg::*;
(
   input  logic     clk,
   input  logic     rst,
   input  logic     ale,
   input  logic [1:0] addr,
   input  logic     ce_hi,
   input  logic     ce_lo_n,
   input  logic     io_sel,
   output pio_sel_e sel_q,
   output logic     cs_q,
   output logic     io_q
);
   // capture follows the address phase; the last captured values are kept
   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q <= SEL_A_DATA;
         cs_q  <= 1'b0;
         io_q  <= 1'b0;
      end else if (ale) begin
         sel_q <= pio_sel_e'(addr);
         cs_q  <= ce_hi & ~ce_lo_n;
         io_q  <= io_sel;
      end
   end
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_dat,
   input  logic          wr_dir,
   input  logic [DW-1:0] din,
   input  logic [DW-1:0] pin_in,
   output logic [DW-1:0] out_q,
   output logic [DW-1:0] dir_q,
   output logic [DW-1:0] rd_mix
);
   always_ff @(posedge clk) begin
      if (rst) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         if (wr_dat) out_q <= din;
         if (wr_dir) dir_q <= din;
      end
   end

   // output bits read back the latch, input bits read the pin
   assign rd_mix = (pin_in & ~dir_q) | (out_q & dir_q);
endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
   import pio_pkg::*;
#(
   parameter int unsigned DW            = 8,
   parameter bit          MEM_READ_PATH = 1'b1
) (
   input  pio_sel_e      sel_q,
   input  logic          cs_q,
   input  logic          io_q,
   input  logic          ale,
   input  logic          io_rd_n,
   input  logic          mem_rd_n,
   input  logic [DW-1:0] mix [NPORT],
   input  logic [DW-1:0] dir [NPORT],
   output logic [DW-1:0] bus_out,
   output logic          bus_oe
);
   logic strobe;

   generate
      if (MEM_READ_PATH) begin : g_two_strobes
         assign strobe = ~io_rd_n | (~mem_rd_n & io_q);
      end else begin : g_io_strobe_only
         logic unused_mem;
         assign unused_mem = mem_rd_n ^ io_q;
         assign strobe = ~io_rd_n;
      end
   endgenerate

   assign bus_oe = cs_q & ~ale & strobe;

   always_comb begin
      unique case (sel_q)
         SEL_A_DATA: bus_out = mix[0];
         SEL_B_DATA: bus_out = mix[1];
         SEL_A_DIR:  bus_out = dir[0];
         SEL_B_DIR:  bus_out = dir[1];
         default:    bus_out = '0;
      endcase
   end
endmodule

// File: rtl/mux_bus_pio.sv
module mux_bus_pio
   import pio_pkg::*;
#(
   parameter int unsigned DW            = 8,
   parameter bit          MEM_READ_PATH = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ale,
   input  logic          ce_hi,
   input  logic          ce_lo_n,
   input  logic          io_sel,
   input  logic          mem_rd_n,
   input  logic          io_rd_n,
   input  logic          io_wr_n,
   input  logic [DW-1:0] bus_in,
   output logic [DW-1:0] bus_out,
   output logic          bus_oe,
   input  logic [DW-1:0] pa_in,
   output logic [DW-1:0] pa_out,
   output logic [DW-1:0] pa_oe,
   input  logic [DW-1:0] pb_in,
   output logic [DW-1:0] pb_out,
   output logic [DW-1:0] pb_oe
);
   localparam int unsigned SELW = 2;

   generate
      if (DW < SELW) begin : g_bad_width
         $error("mux_bus_pio: DW must cover the register select bits");
      end
   endgenerate

   pio_sel_e      sel_q;
   logic          cs_q;
   logic          io_q;
   logic          wr_en;
   logic [DW-1:0] pin_in [NPORT];
   logic [DW-1:0] out_q  [NPORT];
   logic [DW-1:0] dir_q  [NPORT];
   logic [DW-1:0] mix    [NPORT];

   pio_addr_latch u_alat (
      .clk     (clk),
      .rst     (rst),
      .ale     (ale),
      .addr    (bus_in[SELW-1:0]),
      .ce_hi   (ce_hi),
      .ce_lo_n (ce_lo_n),
      .io_sel  (io_sel),
      .sel_q   (sel_q),
      .cs_q    (cs_q),
      .io_q    (io_q)
   );

   assign wr_en     = cs_q & ~ale & ~io_wr_n;
   assign pin_in[0] = pa_in;
   assign pin_in[1] = pb_in;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      localparam pio_sel_e DAT_SEL = (p == 0) ? SEL_A_DATA : SEL_B_DATA;
      localparam pio_sel_e DIR_SEL = (p == 0) ? SEL_A_DIR  : SEL_B_DIR;
      logic wr_dat;
      logic wr_dir;
      assign wr_dat = wr_en & (sel_q == DAT_SEL);
      assign wr_dir = wr_en & (sel_q == DIR_SEL);

      pio_port #(.DW(DW)) u_port (
         .clk    (clk),
         .rst    (rst),
         .wr_dat (wr_dat),
         .wr_dir (wr_dir),
         .din    (bus_in),
         .pin_in (pin_in[p]),
         .out_q  (out_q[p]),
         .dir_q  (dir_q[p]),
         .rd_mix (mix[p])
      );
   end

   pio_read_mux #(.DW(DW), .MEM_READ_PATH(MEM_READ_PATH)) u_rmux (
      .sel_q    (sel_q),
      .cs_q     (cs_q),
      .io_q     (io_q),
      .ale      (ale),
      .io_rd_n  (io_rd_n),
      .mem_rd_n (mem_rd_n),
      .mix      (mix),
      .dir      (dir_q),
      .bus_out  (bus_out),
      .bus_oe   (bus_oe)
   );

   assign pa_out = out_q[0];
   assign pa_oe  = dir_q[0];
   assign pb_out = out_q[1];
   assign pb_oe  = dir_q[1];
endmodule

// File: rtl/pio_checker.sv
module pio_checker #(
   parameter int unsigned DW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic          ale,
   input logic          io_rd_n,
   input logic          mem_rd_n,
   input logic          io_wr_n,
   input logic          bus_oe,
   input logic [DW-1:0] pa_out,
   input logic [DW-1:0] pa_oe,
   input logic [DW-1:0] pb_out,
   input logic [DW-1:0] pb_oe,
   input logic          cs_q,
   input logic          io_q
);
   p_oe_needs_strobe_r8: assert property (@(posedge clk) disable iff (rst)
      bus_oe |-> (!ale && (!io_rd_n || !mem_rd_n)));

   p_bus_quiet_unselected_r4: assert property (@(posedge clk) disable iff (rst)
      bus_oe |-> cs_q);

   p_mem_read_needs_io_r6: assert property (@(posedge clk) disable iff (rst)
      (bus_oe && io_rd_n) |-> io_q);

   p_regs_hold_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
      io_wr_n |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pa_out) && $stable(pb_out)));

   p_no_write_unselected_r4: assert property (@(posedge clk) disable iff (rst)
      !cs_q |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pa_out) && $stable(pb_out)));

   p_reset_inputs_r9: assert property (@(posedge clk)
      rst |=> (pa_oe == '0 && pb_oe == '0 && pa_out == '0 && pb_out == '0));
endmodule

bind mux_bus_pio pio_checker #(.DW(DW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ale      (ale),
   .io_rd_n  (io_rd_n),
   .mem_rd_n (mem_rd_n),
   .io_wr_n  (io_wr_n),
   .bus_oe   (bus_oe),
   .pa_out   (pa_out),
   .pa_oe    (pa_oe),
   .pb_out   (pb_out),
   .pb_oe    (pb_oe),
   .cs_q     (cs_q),
   .io_q     (io_q)
);

// File: tb/tb_mux_bus_pio.sv
module tb_mux_bus_pio;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ale = 1'b0, ce_hi = 1'b1, ce_lo_n = 1'b0, io_sel = 1'b0;
   logic       mem_rd_n = 1'b1, io_rd_n = 1'b1, io_wr_n = 1'b1;
   logic [7:0] bus_in = 8'h00, pa_in = 8'h55, pb_in = 8'hA5;
   logic [7:0] bus_out, pa_out, pa_oe, pb_out, pb_oe;
   logic       bus_oe;

   int total = 0;
   int bad   = 0;
   bit chk_on = 1'b0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   mux_bus_pio dut (
      .clk(clk), .rst(rst), .ale(ale), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .io_sel(io_sel), .mem_rd_n(mem_rd_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
   );

   // behavioural reference model
   int   m_sel = 0;
   bit   m_cs  = 0;
   bit   m_io  = 0;
   logic [7:0] m_dat [2] = '{8'h00, 8'h00};
   logic [7:0] m_dir [2] = '{8'h00, 8'h00};

   always @(posedge clk) begin
      if (rst) begin
         m_sel = 0; m_cs = 0; m_io = 0;
         m_dat[0] = 0; m_dat[1] = 0; m_dir[0] = 0; m_dir[1] = 0;
      end else if (ale) begin
         m_sel = int'(bus_in[1:0]);
         m_cs  = (ce_hi == 1'b1) && (ce_lo_n == 1'b0);
         m_io  = io_sel;
      end else if (m_cs && !io_wr_n) begin
         if (m_sel >= 2) m_dir[m_sel-2] = bus_in;
         else            m_dat[m_sel]   = bus_in;
      end
   end

   function automatic logic [7:0] m_value();
      logic [7:0] pin;
      if (m_sel >= 2) return m_dir[m_sel-2];
      pin = (m_sel == 0) ? pa_in : pb_in;
      return (pin & ~m_dir[m_sel]) | (m_dat[m_sel] & m_dir[m_sel]);
   endfunction

   task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (chk_on) begin
         logic exp_oe;
         exp_oe = !ale && m_cs && (!io_rd_n || (!mem_rd_n && m_io));
         check8("R8", "bus_oe", {7'b0, bus_oe}, {7'b0, exp_oe});
         if (exp_oe) check8("R7", "bus_out", bus_out, m_value());
         check8("R3", "pa_oe", pa_oe, m_dir[0]);
         check8("R3", "pb_oe", pb_oe, m_dir[1]);
         check8("R2", "pa_out", pa_out, m_dat[0]);
         check8("R2", "pb_out", pb_out, m_dat[1]);
      end
   end

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic addr_phase(logic [1:0] sel, logic iosp, logic en_h, logic en_l);
      ale = 1'b1; bus_in = {6'b0, sel}; io_sel = iosp; ce_hi = en_h; ce_lo_n = en_l;
      tick();
      ale = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0; io_sel = 1'b0;
      tick();
   endtask

   task automatic wr(logic [7:0] d);
      bus_in = d; tick();
      io_wr_n = 1'b0; tick(); tick();
      io_wr_n = 1'b1; tick();
   endtask

   // holds a read strobe, checks bus at the next negedge, releases
   task automatic rd(bit use_mem, string req, logic exp_oe, logic [7:0] exp_v);
      if (use_mem) mem_rd_n = 1'b0; else io_rd_n = 1'b0;
      @(negedge clk);
      check8(req, "read oe", {7'b0, bus_oe}, {7'b0, exp_oe});
      if (exp_oe) check8(req, "read value", bus_out, exp_v);
      #1;
      mem_rd_n = 1'b1; io_rd_n = 1'b1;
      tick();
   endtask

   initial begin
      tick(); tick(); tick();
      chk_on = 1'b1;
      tick();
      rst = 1'b0;
      tick();
      // R9: reset state
      check8("R9", "pa_oe after reset", pa_oe, 8'h00);
      check8("R9", "pb_oe after reset", pb_oe, 8'h00);
      check8("R9", "pa_out after reset", pa_out, 8'h00);
      addr_phase(2'b00, 1'b0, 1'b1, 1'b0);
      rd(0, "R9", 1'b1, 8'h55);
      pa_in = 8'hAA;
      rd(0, "R5", 1'b1, 8'hAA);
      // R2/R3: direction then data on port A
      addr_phase(2'b10, 1'b0, 1'b1, 1'b0); wr(8'hFF);
      check8("R3", "pa_oe all outputs", pa_oe, 8'hFF);
      addr_phase(2'b00, 1'b0, 1'b1, 1'b0); wr(8'h66);
      check8("R2", "pa_out after write", pa_out, 8'h66);
      wr(8'h99);
      check8("R2", "pa_out second write", pa_out, 8'h99);
      rd(0, "R7", 1'b1, 8'h99);
      // R7: mixed direction on port B
      addr_phase(2'b11, 1'b0, 1'b1, 1'b0); wr(8'h0F);
      addr_phase(2'b01, 1'b0, 1'b1, 1'b0); wr(8'h99);
      check8("R3", "pb_out latch", pb_out, 8'h99);
      rd(0, "R7", 1'b1, 8'hA9);
      // R6: memory-strobe read with and without I/O space
      addr_phase(2'b11, 1'b1, 1'b1, 1'b0);
      rd(1, "R6", 1'b1, 8'h0F);
      addr_phase(2'b11, 1'b0, 1'b1, 1'b0);
      rd(1, "R6", 1'b0, 8'h00);
      // R4: each enable failing blocks writes and reads
      addr_phase(2'b00, 1'b0, 1'b0, 1'b0); wr(8'h11);
      check8("R4", "pa_out unchanged, ce_hi low", pa_out, 8'h99);
      rd(0, "R4", 1'b0, 8'h00);
      addr_phase(2'b10, 1'b0, 1'b1, 1'b1); wr(8'h00);
      check8("R4", "pa_oe unchanged, ce_lo_n high", pa_oe, 8'hFF);
      // R1: data bits [1:0]=11 do not retarget a port A data write
      addr_phase(2'b00, 1'b0, 1'b1, 1'b0); wr(8'h77);
      check8("R1", "pa_out got data", pa_out, 8'h77);
      check8("R1", "pb_oe untouched", pb_oe, 8'h0F);
      // R8: strobe during address phase gives no drive
      ale = 1'b1; bus_in = 8'h00; io_rd_n = 1'b0;
      @(negedge clk);
      check8("R8", "oe during ale", {7'b0, bus_oe}, 8'h00);
      #1; io_rd_n = 1'b1; ale = 1'b0; tick();
      // R9: reset again, pins return to inputs
      rst = 1'b1; tick(); rst = 1'b0; tick();
      check8("R9", "pa_oe cleared", pa_oe, 8'h00);
      check8("R9", "pb_out cleared", pb_out, 8'h00);
      pa_in = 8'h55;
      addr_phase(2'b00, 1'b0, 1'b1, 1'b0);
      rd(0, "R9", 1'b1, 8'h55);
      tick();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule